// File: doc/BRIEF.md
# Hash Chaining-State Save and Restore Port

This block is the register-side port of a hash engine through which software suspends and resumes a hashing job. The engine's chaining state is a bank of 32-bit words. A single chain-data address reaches every word: each access moves an internal word index one step, so repeated reads walk the state out and repeated writes walk it back in. How many words belong to a job depends on the algorithm selected in the mode register. Two more registers expose the 64-bit processed-length counter. Software may read and write both halves of it so that an interrupted message can be resumed.

The compression rounds are not part of the block. A busy timer stands in for them. It runs for a fixed number of cycles after an operation starts and, while it runs, rewrites each active state word with a simple deterministic mixing step. When the timer ends it adds the job's byte count to the length counter. While the engine is busy, the port shields the state: it ignores chain writes, returns zero on chain reads, and freezes the index, the length and the mode. Once busy clears, the words read out are the engine's result. For a finished message that result is the digest, and software keeps only the leading words the algorithm needs: 7 for the 224-bit variant and 12 for the 384-bit one.

Top module: `hash_state_port`

## Requirements
- R1: A read request (`reg_rd` high, `reg_wr` low) returns data on `reg_rdata` with `reg_rvalid` high in the cycle after the request, and `reg_rvalid` is low in every other cycle. When `reg_wr` and `reg_rd` are both high, only the write is performed and no read data is returned. Register offsets are: mode 0x00, chain data 0x04, status 0x58 (bit 0 = busy), length low word 0x60, length high word 0x64. Any other offset reads as zero.
- R2: The mode register holds the algorithm code in bits 18:16, the keyed-hash enable in bit 22 and a 6-bit byte-order field in bits 31:26. All other bits read as zero. Writes to the mode register while busy is high are ignored.
- R3: Algorithm codes are 0 = SHA-256, 1 = SHA-224, 2 = SHA-384, 3 = SHA-512 and 4 = SM3. Codes 2 and 3 use 16 state words. Every other code, including undefined ones, uses 8.
- R4: Each chain-data read returns the word at the current index and then advances the index. After the last word for the current algorithm, the index wraps to 0.
- R5: Each chain-data write while not busy stores the data at the current index and then advances the index, with the same wrap rule as R4.
- R6: The index returns to 0 when a mode write is accepted and when an operation start is accepted.
- R7: An `op_start` pulse while idle makes `busy` high for exactly BUSY_CYCLES cycles. The busy flag is also visible in status bit 0. An `op_start` while busy is ignored.
- R8: While busy, chain writes are ignored, chain reads return zero, and neither of them moves the index.
- R9: When an operation completes, each state word k below the word count latched at start becomes {w[30:0], w[31]} XOR {k[15:0], op_bytes[15:0]}, where w is the word's earlier value. Words at or above the latched count are unchanged.
- R10: The 64-bit length counter increases by `op_bytes` when an operation completes, with a carry from the low word into the high word. Software writes to either half take effect only while not busy.
- R11: After reset, `busy` and `reg_rvalid` are low, and the mode register and both length words read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after the request |
| op_start | input | 1 | Pulse that starts an engine operation |
| op_bytes | input | BYTES_W | Byte count of the operation |
| busy | output | 1 | Engine busy |

## Verification
Read data is due in the cycle after the read request, so the bench raises a request at a falling edge and samples `reg_rdata` and `reg_rvalid` at the next falling edge, which is one rising edge later. `busy` rises on the rising edge that accepts `op_start` and stays high for BUSY_CYCLES rising edges. The bench therefore counts falling-edge samples with `busy` high and expects exactly BUSY_CYCLES of them. State words and the length counter take their new values on the edge where busy falls, so the bench reads them only after it has seen `busy` low. Probes made inside the busy window check zero read data, writes that are ignored, and an index that does not move.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ALG_SHA256 = 3'd0,
    ALG_SHA224 = 3'd1,
    ALG_SHA384 = 3'd2,
    ALG_SHA512 = 3'd3,
    ALG_SM3    = 3'd4
  } alg_e;

  typedef struct packed {
    logic [5:0] byte_order;
    logic       keyed;
    logic [2:0] algo;
  } mode_t;

  localparam logic [7:0] OFS_MODE   = 8'h00;
  localparam logic [7:0] OFS_CHAIN  = 8'h04;
  localparam logic [7:0] OFS_STATUS = 8'h58;
  localparam logic [7:0] OFS_LEN_LO = 8'h60;
  localparam logic [7:0] OFS_LEN_HI = 8'h64;

  function automatic logic is_wide(input logic [2:0] algo);
    return (algo == ALG_SHA384) || (algo == ALG_SHA512);
  endfunction

  function automatic logic [WORD_W-1:0] mix_word(input logic [WORD_W-1:0] w,
                                                 input logic [15:0] k,
                                                 input logic [15:0] b);
    return {w[WORD_W-2:0], w[WORD_W-1]} ^ {k, b};
  endfunction

endpackage

// File: rtl/hsp_state_bank.sv
module hsp_state_bank #(
  parameter int WORDS  = 16,
  parameter int WIDTH  = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [WIDTH-1:0] rdata_b
);

  // Distributed-RAM style: one synchronous write port, two asynchronous reads.
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/hsp_engine.sv
module hsp_engine
  import hsp_pkg::*;
#(
  parameter int NARROW_WORDS = 8,
  parameter int WIDE_WORDS   = 16,
  parameter int BUSY_CYCLES  = 20,
  parameter int BYTES_W      = 16,
  localparam int IDX_W = $clog2(WIDE_WORDS),
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_acc,
  input  logic [BYTES_W-1:0] start_bytes,
  input  logic               wide_sel,
  output logic               busy,
  output logic               upd_we,
  output logic [IDX_W-1:0]   upd_idx,
  input  logic [WORD_W-1:0]  upd_old,
  output logic [WORD_W-1:0]  upd_new,
  output logic               done,
  output logic [BYTES_W-1:0] done_bytes
);

  logic [CNT_W-1:0]   cnt_q;
  logic [BYTES_W-1:0] bytes_q;
  logic [IDX_W:0]     nwords_q;
  logic               busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      bytes_q  <= '0;
      nwords_q <= '0;
    end else if (!busy_q && start_acc) begin
      busy_q   <= 1'b1;
      cnt_q    <= '0;
      bytes_q  <= start_bytes;
      nwords_q <= wide_sel ? (IDX_W+1)'(WIDE_WORDS) : (IDX_W+1)'(NARROW_WORDS);
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(BUSY_CYCLES - 1)) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // One state word is rewritten per busy cycle, starting with word 0.
  assign upd_we     = busy_q && (32'(cnt_q) < 32'(nwords_q));
  assign upd_idx    = IDX_W'(cnt_q);
  assign upd_new    = mix_word(upd_old, 16'(cnt_q), 16'(bytes_q));
  assign done       = busy_q && (cnt_q == CNT_W'(BUSY_CYCLES - 1));
  assign done_bytes = bytes_q;
  assign busy       = busy_q;

endmodule

// File: rtl/hsp_regif.sv
module hsp_regif
  import hsp_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int NARROW_WORDS = 8,
  parameter int WIDE_WORDS   = 16,
  parameter int BYTES_W      = 16,
  localparam int IDX_W = $clog2(WIDE_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  input  logic               busy,
  input  logic               start_acc,
  input  logic               done,
  input  logic [BYTES_W-1:0] done_bytes,
  input  logic [WORD_W-1:0]  chain_word,
  output logic               chain_we,
  output logic [IDX_W-1:0]   chain_idx,
  output logic [WORD_W-1:0]  chain_wdata,
  output logic               wide_sel,
  output mode_t              mode_q,
  output logic [63:0]        len_q
);

  logic hit_mode, hit_chain, hit_status, hit_lo, hit_hi;
  logic wr_acc, rd_acc, chain_step;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] idx_q;
  logic [WORD_W-1:0] rd_mux;

  assign hit_mode   = reg_addr == ADDR_W'(OFS_MODE);
  assign hit_chain  = reg_addr == ADDR_W'(OFS_CHAIN);
  assign hit_status = reg_addr == ADDR_W'(OFS_STATUS);
  assign hit_lo     = reg_addr == ADDR_W'(OFS_LEN_LO);
  assign hit_hi     = reg_addr == ADDR_W'(OFS_LEN_HI);

  assign wr_acc     = reg_wr && !busy;
  assign rd_acc     = reg_rd && !reg_wr;
  assign chain_step = !busy && hit_chain && (reg_wr || reg_rd);

  assign wide_sel = is_wide(mode_q.algo);
  assign last_idx = wide_sel ? IDX_W'(WIDE_WORDS - 1) : IDX_W'(NARROW_WORDS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (wr_acc && hit_mode) begin
      mode_q.algo       <= reg_wdata[18:16];
      mode_q.keyed      <= reg_wdata[22];
      mode_q.byte_order <= reg_wdata[31:26];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if ((wr_acc && hit_mode) || start_acc) begin
      idx_q <= '0;
    end else if (chain_step) begin
      idx_q <= (idx_q == last_idx) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
    end else if (done) begin
      len_q <= len_q + 64'(done_bytes);
    end else if (wr_acc && hit_lo) begin
      len_q[31:0] <= reg_wdata;
    end else if (wr_acc && hit_hi) begin
      len_q[63:32] <= reg_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_mode)   rd_mux = {mode_q.byte_order, 3'b0, mode_q.keyed, 3'b0, mode_q.algo, 16'h0};
    if (hit_chain)  rd_mux = busy ? '0 : chain_word;
    if (hit_status) rd_mux = {31'h0, busy};
    if (hit_lo)     rd_mux = len_q[31:0];
    if (hit_hi)     rd_mux = len_q[63:32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= rd_acc;
      if (rd_acc) reg_rdata <= rd_mux;
    end
  end

  assign chain_we    = wr_acc && hit_chain;
  assign chain_idx   = idx_q;
  assign chain_wdata = reg_wdata;

endmodule

// File: rtl/hash_state_port.sv
module hash_state_port
  import hsp_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int NARROW_WORDS = 8,
  parameter int WIDE_WORDS   = 16,
  parameter int BUSY_CYCLES  = 20,
  parameter int BYTES_W      = 16,
  localparam int IDX_W = $clog2(WIDE_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               reg_rvalid,
  input  logic               op_start,
  input  logic [BYTES_W-1:0] op_bytes,
  output logic               busy
);

  logic               start_acc;
  logic               wide_sel;
  logic               eng_we, rif_we;
  logic [IDX_W-1:0]   eng_idx, chain_idx;
  logic [WORD_W-1:0]  eng_old, eng_new, rif_wdata, chain_word;
  logic               done;
  logic [BYTES_W-1:0] done_bytes;
  mode_t              mode_q;
  logic [63:0]        len_q;

  assign start_acc = op_start && !busy;

  hsp_engine #(
    .NARROW_WORDS(NARROW_WORDS), .WIDE_WORDS(WIDE_WORDS),
    .BUSY_CYCLES(BUSY_CYCLES), .BYTES_W(BYTES_W)
  ) u_engine (
    .clk(clk), .rst(rst), .start_acc(start_acc), .start_bytes(op_bytes),
    .wide_sel(wide_sel), .busy(busy), .upd_we(eng_we), .upd_idx(eng_idx),
    .upd_old(eng_old), .upd_new(eng_new), .done(done), .done_bytes(done_bytes)
  );

  hsp_regif #(
    .ADDR_W(ADDR_W), .NARROW_WORDS(NARROW_WORDS),
    .WIDE_WORDS(WIDE_WORDS), .BYTES_W(BYTES_W)
  ) u_regif (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .busy(busy), .start_acc(start_acc),
    .done(done), .done_bytes(done_bytes), .chain_word(chain_word),
    .chain_we(rif_we), .chain_idx(chain_idx), .chain_wdata(rif_wdata),
    .wide_sel(wide_sel), .mode_q(mode_q), .len_q(len_q)
  );

  // Ownership of the single write port follows busy; the two sides never overlap.
  hsp_state_bank #(.WORDS(WIDE_WORDS), .WIDTH(WORD_W)) u_bank (
    .clk(clk),
    .we(busy ? eng_we : rif_we),
    .waddr(busy ? eng_idx : chain_idx),
    .wdata(busy ? eng_new : rif_wdata),
    .raddr_a(chain_idx), .rdata_a(chain_word),
    .raddr_b(eng_idx), .rdata_b(eng_old)
  );

endmodule

// File: rtl/hash_state_port_chk.sv
module hash_state_port_chk #(
  parameter int ADDR_W       = 8,
  parameter int NARROW_WORDS = 8,
  parameter int WIDE_WORDS   = 16,
  parameter int BUSY_CYCLES  = 20,
  localparam int IDX_W = $clog2(WIDE_WORDS)
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              reg_rvalid,
  input logic              busy,
  input logic              wide_sel,
  input logic [9:0]        mode_bits,
  input logic [63:0]       len_q,
  input logic [IDX_W-1:0]  chain_idx
);

  logic [31:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  assert_rvalid_R1: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr) |=> reg_rvalid);

  assert_no_rvalid_R1: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && !reg_wr) |=> !reg_rvalid);

  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mode_bits));

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
    32'(chain_idx) < (wide_sel ? WIDE_WORDS : NARROW_WORDS));

  assert_busy_window_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> busy_run < 32'(BUSY_CYCLES));

  assert_busy_zero_read_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr && busy && reg_addr == ADDR_W'(8'h04)) |=> reg_rdata == 32'h0);

  assert_idx_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(chain_idx));

  assert_len_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(len_q)));

endmodule

bind hash_state_port hash_state_port_chk #(
  .ADDR_W(ADDR_W), .NARROW_WORDS(NARROW_WORDS),
  .WIDE_WORDS(WIDE_WORDS), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .busy(busy),
  .wide_sel(wide_sel), .mode_bits(mode_q), .len_q(len_q), .chain_idx(chain_idx)
);

// File: tb/tb_hash_state_port.sv
module tb_hash_state_port;

  localparam int BUSY_CYCLES = 20;
  localparam logic [7:0] A_MODE = 8'h00, A_CHAIN = 8'h04, A_STAT = 8'h58,
                         A_LO = 8'h60, A_HI = 8'h64;

  typedef struct packed {
    logic [2:0]  algo;
    logic [15:0] bytes;
    logic [4:0]  nwords;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{algo: 3'd0, bytes: 16'h0040, nwords: 5'd8},
    '{algo: 3'd1, bytes: 16'h0080, nwords: 5'd8},
    '{algo: 3'd2, bytes: 16'h0100, nwords: 5'd16},
    '{algo: 3'd3, bytes: 16'h1234, nwords: 5'd16},
    '{algo: 3'd4, bytes: 16'h0003, nwords: 5'd8},
    '{algo: 3'd7, bytes: 16'h00ff, nwords: 5'd8}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        op_start = 1'b0;
  logic [15:0] op_bytes = '0;
  logic        busy;

  int n_checks = 0;
  int n_errs = 0;
  logic finished = 1'b0;
  logic [63:0] len_m = '0;
  logic [31:0] orig [16];
  logic [31:0] got;

  always #2.5 clk = ~clk;

  hash_state_port dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .op_start(op_start), .op_bytes(op_bytes),
    .busy(busy)
  );

  function automatic logic [31:0] mixm(input logic [31:0] w, input int k,
                                       input logic [15:0] b);
    return {w[30:0], w[31]} ^ {k[15:0], b};
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
    check("R1 rvalid", 64'(reg_rvalid), 64'd1);
  endtask

  task automatic start(input logic [15:0] b);
    @(negedge clk);
    op_start = 1'b1; op_bytes = b;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 busy", 64'(busy), 64'd0);
    check("R11 rvalid", 64'(reg_rvalid), 64'd0);
    rd(A_MODE, got); check("R11 mode", 64'(got), 64'd0);
    rd(A_LO, got);   check("R11 len lo", 64'(got), 64'd0);
    rd(A_HI, got);   check("R11 len hi", 64'(got), 64'd0);
    rd(A_STAT, got); check("R7 status idle", 64'(got), 64'd0);
    rd(8'h30, got);  check("R1 unmapped", 64'(got), 64'd0);

    // Table: R3 word count and R9 update per algorithm, R10 length accumulation
    for (int e = 0; e < 6; e++) begin
      wr(A_MODE, 32'h0003_0000);
      for (int i = 0; i < 16; i++) begin
        orig[i] = 32'h9E37_79B9 ^ (32'(e) << 20) ^ (32'(i) * 32'h0101_0101);
        wr(A_CHAIN, orig[i]);
      end
      wr(A_MODE, 32'(VEC[e].algo) << 16);
      start(VEC[e].bytes);
      wait_idle();
      len_m = len_m + 64'(VEC[e].bytes);
      wr(A_MODE, 32'h0003_0000);
      for (int i = 0; i < 16; i++) begin
        rd(A_CHAIN, got);
        check("R9 R3 word", 64'(got),
              64'((i < int'(VEC[e].nwords)) ? mixm(orig[i], i, VEC[e].bytes) : orig[i]));
      end
      rd(A_LO, got); check("R10 len lo", 64'(got), 64'(len_m[31:0]));
      rd(A_HI, got); check("R10 len hi", 64'(got), 64'(len_m[63:32]));
    end

    // R2 mode fields
    wr(A_MODE, 32'hFFFF_FFFF);
    rd(A_MODE, got); check("R2 fields", 64'(got), 64'hFC47_0000);

    // R5 writes, R4 wrap at 8 words, R6 index reset on mode write
    wr(A_MODE, 32'h0);
    for (int i = 0; i < 8; i++) begin
      orig[i] = 32'h1000_0000 + 32'(i);
      wr(A_CHAIN, orig[i]);
    end
    for (int i = 0; i < 9; i++) begin
      rd(A_CHAIN, got);
      check("R4 R5 walk", 64'(got), 64'(orig[i % 8]));
    end
    rd(A_CHAIN, got); rd(A_CHAIN, got);
    wr(A_MODE, 32'h0);
    rd(A_CHAIN, got); check("R6 mode reset", 64'(got), 64'(orig[0]));
    rd(A_CHAIN, got); rd(A_CHAIN, got);

    // R8 and R7 probes inside the busy window; index was at 3, op start resets it
    start(16'h0010);
    rd(A_STAT, got);  check("R7 status busy", 64'(got), 64'd1);
    rd(A_CHAIN, got); check("R8 zero read", 64'(got), 64'd0);
    wr(A_CHAIN, 32'hDEAD_BEEF);
    wr(A_LO, 32'h0000_0055);
    wr(A_MODE, 32'h0003_0000);
    start(16'h0700);
    wait_idle();
    len_m = len_m + 64'h10;
    rd(A_MODE, got);  check("R2 ignored busy", 64'(got), 64'd0);
    rd(A_LO, got);    check("R10 R7 single add", 64'(got), 64'(len_m[31:0]));
    rd(A_CHAIN, got); check("R8 R6 word0", 64'(got), 64'(mixm(orig[0], 0, 16'h0010)));
    rd(A_CHAIN, got); check("R8 word1", 64'(got), 64'(mixm(orig[1], 1, 16'h0010)));

    // R7 busy duration, with a second start in the window
    begin
      int cnt;
      cnt = 0;
      @(negedge clk);
      op_start = 1'b1; op_bytes = 16'h0001;
      @(negedge clk);
      op_start = 1'b0;
      while (busy) begin
        cnt++;
        if (cnt == 5) op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
      end
      check("R7 busy cycles", 64'(cnt), 64'(BUSY_CYCLES));
      len_m = len_m + 64'h1;
      rd(A_LO, got); check("R7 no restart", 64'(got), 64'(len_m[31:0]));
    end

    // R10 carry
    wr(A_LO, 32'hFFFF_FFF0);
    wr(A_HI, 32'h0000_0001);
    start(16'h0020);
    wait_idle();
    rd(A_LO, got); check("R10 carry lo", 64'(got), 64'h10);
    rd(A_HI, got); check("R10 carry hi", 64'(got), 64'h2);

    // R1 write wins over simultaneous read
    wr(A_MODE, 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = A_CHAIN; reg_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    check("R1 no rvalid on write", 64'(reg_rvalid), 64'd0);
    wr(A_MODE, 32'h0);
    rd(A_CHAIN, got); check("R1 R5 write taken", 64'(got), 64'hCAFE_F00D);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule